// File: doc/BRIEF.md
# Programmable PWM pulse generator

This block produces one pulse-width-modulated output from a single fast clock. An 8-bit up-counter advances on prescaled timer ticks and returns to zero when it reaches the period value. The output stays high from that return to zero until the counter moves past the compare value. The frequency therefore follows the period input, and the high time follows the compare input.

The timer tick starts from one of two enable sources. The fast source is active on every clock. The slow source is active on one clock in eight. A power-of-two prescaler then divides the chosen source. Two active-low pushbutton lines drive the block. One button steps the prescaler index through 1 to 15 and wraps back to 1. The other button switches between the fast and slow sources. Each button is synchronised and debounced inside the block.

The period, compare and index values go into shadow registers. They take effect only when the counter returns to zero, so a setting that changes mid-cycle cannot shorten or split a pulse.

Top module: `pwm_pulse_gen`

## Requirements
- R1: While `rst` is high, `pulse_o` is 0. The first cycle after reset uses period 199, compare 100, prescaler index 3 and the fast source. The output is therefore high for 101 ticks of 4 clocks, which is 404 clocks.
- R2: With period P, the time from one rising edge of `pulse_o` to the next is (P+1) ticks.
- R3: With compare C less than period P, `pulse_o` is high for (C+1) ticks of each cycle.
- R4: With compare greater than or equal to period, `pulse_o` stays high for the whole cycle.
- R5: Prescaler index n makes one tick every 2^(n-1) source enables. Index 1 does not divide.
- R6: Each press of the prescaler button raises the index by one. A press at index 15 sets the index to 1.
- R7: Each press of the source button toggles the tick source. The fast source enables every clock. The slow source enables every 8th clock. A source change applies immediately.
- R8: New period, compare and index values take effect only when the counter returns to zero. A cycle that is in progress keeps its length.
- R9: A button acts only after its line has stayed low for DEB_CYC consecutive synchronised samples. A shorter low pulse does nothing. Releasing a button does nothing. A long hold counts as one press.
- R10: With the slow source and index 12, one tick lasts 16384 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_psc_n | input | 1 | Raw prescaler-step button, active low |
| btn_src_n | input | 1 | Raw clock-source button, active low |
| period_i | input | 8 | Period value, one cycle lasts period+1 ticks |
| compare_i | input | 8 | Compare value, high for compare+1 ticks |
| pulse_o | output | 1 | Registered PWM output |

## Verification
The assertions assume the button lines and the period and compare values change only between clock edges. They also assume reset is held from time zero, so the shadow registers start from their reset values. The stimulus drives every input on the falling edge. It holds each deliberate press and release for longer than the debounce window. It starts the fast burst of prescaler presses just after an observed rising edge, so the whole burst falls inside one PWM cycle. The only deliberately short low pulse is the glitch that R9 expects to be ignored.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;
  localparam int IDX_W     = 4;
  localparam int IDX_FIRST = 1;
  localparam int IDX_LAST  = 15;
  localparam int NUM_BTN   = 2;
  localparam int BTN_PSC   = 0;
  localparam int BTN_SRC   = 1;

  typedef logic [IDX_W-1:0] psc_idx_t;

  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } clk_src_e;
endpackage

// File: rtl/pwmg_debounce.sv
module pwmg_debounce #(
  parameter int DEB_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n,
  output logic press_o
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic          s1, s2, level;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      level   <= 1'b1;
      cnt     <= '0;
      press_o <= 1'b0;
    end else begin
      s1      <= btn_n;
      s2      <= s1;
      press_o <= level && !s2 && (cnt == LAST);
      if (s2 == level) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwmg_ctrl.sv
module pwmg_ctrl
  import pwmg_pkg::*;
#(
  parameter int IDX_RST = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     psc_press_i,
  input  logic     src_press_i,
  output psc_idx_t idx_sel_o,
  output clk_src_e src_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_sel_o <= psc_idx_t'(IDX_RST);
      src_o     <= SRC_FAST;
    end else begin
      if (psc_press_i) begin
        if (idx_sel_o == psc_idx_t'(IDX_LAST)) idx_sel_o <= psc_idx_t'(IDX_FIRST);
        else                                   idx_sel_o <= idx_sel_o + 1'b1;
      end
      if (src_press_i) begin
        src_o <= (src_o == SRC_FAST) ? SRC_SLOW : SRC_FAST;
      end
    end
  end
endmodule

// File: rtl/pwmg_tick.sv
module pwmg_tick
  import pwmg_pkg::*;
#(
  parameter int SLOW_DIV = 8,
  parameter int PRE_W    = 14
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_src_e src_i,
  input  psc_idx_t idx_i,
  output logic     tick_o
);
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [SW-1:0]    slow_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;
  logic             slow_stb, src_en;

  assign slow_stb = (slow_cnt == SW'(SLOW_DIV - 1));
  assign src_en   = (src_i == SRC_SLOW) ? slow_stb : 1'b1;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(idx_i) - 1) mask[i] = 1'b1;
    end
  end

  assign tick_o = src_en && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_cnt <= '0;
      pre_cnt  <= '0;
    end else begin
      slow_cnt <= slow_stb ? '0 : slow_cnt + 1'b1;
      if (src_en) pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwmg_core.sv
module pwmg_core
  import pwmg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PER_RST = 199,
  parameter int CMP_RST = 100,
  parameter int IDX_RST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] compare_i,
  input  psc_idx_t         idx_sel_i,
  output psc_idx_t         idx_act_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             wrap_o,
  output logic             pulse_o
);
  assign wrap_o = tick_i && (cnt_o == per_act_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o     <= '0;
      per_act_o <= CNT_W'(PER_RST);
      cmp_act_o <= CNT_W'(CMP_RST);
      idx_act_o <= psc_idx_t'(IDX_RST);
      pulse_o   <= 1'b0;
    end else begin
      pulse_o <= (cnt_o <= cmp_act_o);
      if (wrap_o) begin
        cnt_o     <= '0;
        per_act_o <= period_i;
        cmp_act_o <= compare_i;
        idx_act_o <= idx_sel_i;
      end else if (tick_i) begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_pulse_gen.sv
module pwm_pulse_gen
  import pwmg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PER_RST  = 199,
  parameter int CMP_RST  = 100,
  parameter int IDX_RST  = 3,
  parameter int SLOW_DIV = 8,
  parameter int PRE_W    = 14,
  parameter int DEB_CYC  = 50000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_psc_n,
  input  logic             btn_src_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] compare_i,
  output logic             pulse_o
);
  logic [NUM_BTN-1:0] btn_raw_n, press;
  psc_idx_t           idx_sel, idx_act;
  clk_src_e           src_sel;
  logic               tick, wrap;
  logic [CNT_W-1:0]   cnt, per_act, cmp_act;

  assign btn_raw_n[BTN_PSC] = btn_psc_n;
  assign btn_raw_n[BTN_SRC] = btn_src_n;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    pwmg_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk(clk), .rst(rst), .btn_n(btn_raw_n[b]), .press_o(press[b])
    );
  end

  pwmg_ctrl #(.IDX_RST(IDX_RST)) u_ctrl (
    .clk(clk), .rst(rst),
    .psc_press_i(press[BTN_PSC]), .src_press_i(press[BTN_SRC]),
    .idx_sel_o(idx_sel), .src_o(src_sel)
  );

  pwmg_tick #(.SLOW_DIV(SLOW_DIV), .PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst(rst), .src_i(src_sel), .idx_i(idx_act), .tick_o(tick)
  );

  pwmg_core #(
    .CNT_W(CNT_W), .PER_RST(PER_RST), .CMP_RST(CMP_RST), .IDX_RST(IDX_RST)
  ) u_core (
    .clk(clk), .rst(rst), .tick_i(tick),
    .period_i(period_i), .compare_i(compare_i), .idx_sel_i(idx_sel),
    .idx_act_o(idx_act), .cnt_o(cnt), .per_act_o(per_act), .cmp_act_o(cmp_act),
    .wrap_o(wrap), .pulse_o(pulse_o)
  );
endmodule

// File: rtl/pwmg_checker.sv
module pwmg_checker
  import pwmg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             press_psc,
  input logic             press_src,
  input psc_idx_t         idx_sel,
  input psc_idx_t         idx_act,
  input clk_src_e         src_sel,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] cmp_act,
  input logic             wrap,
  input logic             pulse_o
);
  // R2: counter never runs past the active period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_act);

  // R4: compare at or above period keeps the output high
  p_full_high_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_act >= per_act) |=> pulse_o);

  // R6: index stays inside 1..15 and wraps from 15 to 1
  p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
    (idx_sel >= psc_idx_t'(IDX_FIRST)) && (idx_sel <= psc_idx_t'(IDX_LAST)));
  p_idx_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (press_psc && idx_sel == psc_idx_t'(IDX_LAST)) |=> (idx_sel == psc_idx_t'(IDX_FIRST)));

  // R7: source flips on a press and holds otherwise
  p_src_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    press_src |=> (src_sel != $past(src_sel)));
  p_src_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !press_src |=> $stable(src_sel));

  // R8: shadow values change only at a period boundary
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(per_act) && $stable(cmp_act) && $stable(idx_act)));

  // R9: a press is a single-cycle event
  p_press_single_r9: assert property (@(posedge clk) disable iff (rst)
    press_psc |=> !press_psc);
endmodule

bind pwm_pulse_gen pwmg_checker #(.CNT_W(CNT_W)) u_pwmg_chk (
  .clk(clk), .rst(rst),
  .press_psc(press[pwmg_pkg::BTN_PSC]), .press_src(press[pwmg_pkg::BTN_SRC]),
  .idx_sel(idx_sel), .idx_act(idx_act), .src_sel(src_sel),
  .cnt(cnt), .per_act(per_act), .cmp_act(cmp_act),
  .wrap(wrap), .pulse_o(pulse_o)
);

// File: tb/test_pwm_pulse_gen.sv
`timescale 1ns/1ps
module test_pwm_pulse_gen;
  localparam int DEB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_psc_n = 1'b1;
  logic       btn_src_n = 1'b1;
  logic [7:0] period_i  = 8'd50;
  logic [7:0] compare_i = 8'd10;
  logic       pulse_o;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pwm_pulse_gen #(.DEB_CYC(DEB)) i_pwm_pulse_gen (
    .clk(clk), .rst(rst), .btn_psc_n(btn_psc_n), .btn_src_n(btn_src_n),
    .period_i(period_i), .compare_i(compare_i), .pulse_o(pulse_o)
  );

  // behavioural reference
  int m_cnt, m_per, m_cmp, m_idx, m_isel, m_pre, m_slow;
  bit m_src, m_pulse;
  bit m_s1[2], m_s2[2], m_lv[2], m_pr[2];
  int m_dc[2];

  always @(posedge clk) begin : ref_model
    int div;
    bit en, tk;
    bit raw[2];
    bit pr_old[2];
    if (rst) begin
      m_cnt = 0; m_per = 199; m_cmp = 100; m_idx = 3; m_isel = 3;
      m_pre = 0; m_slow = 0; m_src = 0; m_pulse = 0;
      for (int b = 0; b < 2; b++) begin
        m_s1[b] = 1; m_s2[b] = 1; m_lv[b] = 1; m_pr[b] = 0; m_dc[b] = 0;
      end
    end else begin
      raw[0] = btn_psc_n; raw[1] = btn_src_n;
      pr_old[0] = m_pr[0]; pr_old[1] = m_pr[1];
      en  = m_src ? (m_slow == 7) : 1'b1;
      div = 1 << (m_idx - 1);
      tk  = en && ((m_pre % div) == div - 1);
      m_pulse = (m_cnt <= m_cmp);
      if (tk) begin
        if (m_cnt == m_per) begin
          m_cnt = 0; m_per = period_i; m_cmp = compare_i; m_idx = m_isel;
        end else m_cnt++;
      end
      if (en) m_pre = (m_pre + 1) % 16384;
      m_slow = (m_slow + 1) % 8;
      if (pr_old[1]) m_src = !m_src;
      if (pr_old[0]) m_isel = (m_isel == 15) ? 1 : m_isel + 1;
      for (int b = 0; b < 2; b++) begin
        m_pr[b] = (m_s2[b] == 0) && (m_lv[b] == 1) && (m_dc[b] == DEB - 1);
        if (m_s2[b] == m_lv[b]) m_dc[b] = 0;
        else if (m_dc[b] == DEB - 1) begin m_lv[b] = m_s2[b]; m_dc[b] = 0; end
        else m_dc[b]++;
        m_s2[b] = m_s1[b];
        m_s1[b] = raw[b];
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (pulse_o !== m_pulse) begin
      miscompares++;
      $display("FAIL %s cycle compare pulse_o act=%0b exp=%0b at %0t", cur_req, pulse_o, m_pulse, $time);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = pulse_o;
    @(negedge clk);
    while (!(pulse_o && !p)) begin
      p = pulse_o;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int hi, output int pe);
    wait_rise();
    hi = 1;
    @(negedge clk);
    while (pulse_o) begin hi++; @(negedge clk); end
    pe = hi + 1;
    @(negedge clk);
    while (!pulse_o) begin pe++; @(negedge clk); end
  endtask

  task automatic press_psc(input int low_len);
    btn_psc_n = 1'b0; repeat (low_len) @(negedge clk);
    btn_psc_n = 1'b1; repeat (DEB + 4) @(negedge clk);
  endtask

  task automatic press_src(input int low_len);
    btn_src_n = 1'b0; repeat (low_len) @(negedge clk);
    btn_src_n = 1'b1; repeat (DEB + 4) @(negedge clk);
  endtask

  task automatic run_all();
    int hi, pe, n, lows;
    // R1 reset state and defaults
    repeat (5) @(negedge clk);
    chk(pulse_o == 1'b0, "R1 low in reset", pulse_o, 0);
    rst = 1'b0;
    @(negedge clk);
    hi = 0;
    while (pulse_o) begin hi++; @(negedge clk); end
    chk(hi == 404, "R1 default high time", hi, 404);
    // R2 R3 new period and compare
    cur_req = "R2";
    measure(hi, pe);
    chk(pe == 204, "R2 period", pe, 204);
    chk(hi == 44, "R3 high time", hi, 44);
    // R4 compare above period
    cur_req = "R4";
    compare_i = 8'd60;
    repeat (600) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      if (!pulse_o) lows++;
      @(negedge clk);
    end
    chk(lows == 0, "R4 full high low samples", lows, 0);
    // R6 wrap burst
    cur_req = "R6";
    period_i = 8'd255; compare_i = 8'd100;
    wait_rise();
    for (int k = 0; k < 13; k++) press_psc(DEB + 4);
    measure(hi, pe);
    chk(pe == 256, "R6 wrap to index 1 period", pe, 256);
    chk(hi == 101, "R5 index 1 undivided high", hi, 101);
    // R8 shadow load at boundary
    cur_req = "R8";
    wait_rise();
    n = 1;
    @(negedge clk);
    while (!(pulse_o && n > 200)) begin
      if (n == 10) begin period_i = 8'd99; compare_i = 8'd40; end
      n++;
      @(negedge clk);
    end
    chk(n == 256, "R8 running cycle kept", n, 256);
    measure(hi, pe);
    chk(pe == 100, "R8 new period applied", pe, 100);
    chk(hi == 41, "R8 new compare applied", hi, 41);
    // R5 index 2
    cur_req = "R5";
    press_psc(DEB + 4);
    measure(hi, pe);
    chk(pe == 200, "R5 index 2 period", pe, 200);
    chk(hi == 82, "R5 index 2 high", hi, 82);
    // R7 slow source
    cur_req = "R7";
    period_i = 8'd3; compare_i = 8'd1;
    press_src(DEB + 4);
    measure(hi, pe);
    chk(pe == 64, "R7 slow period", pe, 64);
    chk(hi == 32, "R7 slow high", hi, 32);
    // R9 glitch ignored, long hold single toggle, release ignored
    cur_req = "R9";
    press_src(2);
    measure(hi, pe);
    chk(pe == 64, "R9 glitch ignored", pe, 64);
    press_src(40);
    measure(hi, pe);
    chk(pe == 8, "R9 long hold one toggle", pe, 8);
    chk(hi == 4, "R9 release ignored high", hi, 4);
    // R10 slow source, index 12
    cur_req = "R10";
    period_i = 8'd1; compare_i = 8'd0;
    press_src(DEB + 4);
    for (int k = 0; k < 10; k++) press_psc(DEB + 4);
    wait_rise();
    measure(hi, pe);
    chk(pe == 32768, "R10 period at index 12 slow", pe, 32768);
    chk(hi == 16384, "R10 one tick is 16384 clocks", hi, 16384);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule